// File: doc/BRIEF.md
# CAN Receive Frame Buffer Queue

This block sits between a CAN bit-level receiver and the CPU. Each time the receiver finishes a frame, it raises a completion strobe. With that strobe it supplies the frame contents, a flag saying the frame arrived without error, a flag saying the identifier passed the acceptance filter, and the index of the filter that matched. The block copies every completed frame into a single scratch (background) register. It decides whether that frame goes into a five-entry queue of foreground slots, or is simply overwritten by the next frame.

The CPU reads the oldest stored frame at the head outputs. It acknowledges that frame with a one-cycle release pulse, which frees the slot and moves the queue forward. When the node sends a frame itself, the block drops its own frame unless loopback is on. A frame the node receives after losing arbitration is not flagged as its own, so it is handled like any other frame. When the queue is full, a further good frame is thrown away and a sticky overrun flag is set. Each of the two flags drives an interrupt output that has its own enable.

Top module: `can_rx_fifo`

## Requirements
- R1: After reset, rx_full, ovr_flag, rx_irq and ovr_irq are all 0.
- R2: A frame is admitted when fd_strobe is 1 with fd_ok=1, fd_acc=1, and either fd_self=0 or loopback=1. An admitted frame is captured at the strobe's clock edge and written into the queue at the next edge. rx_full is 1 exactly when the queue holds at least one frame.
- R3: A completed frame with fd_ok=0 or fd_acc=0 never enters the queue. Its scratch contents are overwritten by the next frame.
- R4: A frame with fd_self=1 enters the queue only when loopback=1. It is then treated exactly like a received frame.
- R5: hd_id, hd_dlc, hd_data and hd_hit show the oldest stored frame. Frames leave the queue in arrival order, one per cpu_release pulse.
- R6: If an admitted frame reaches a queue that holds 5 frames and no release happens in that cycle, the frame is discarded. The stored frames are left unchanged, and ovr_flag becomes 1.
- R7: A release and an admitted write in the same cycle are both carried out, even when the queue is full. No overrun occurs in that case.
- R8: A cpu_release pulse while the queue is empty has no effect.
- R9: rx_irq = rx_full AND rx_ie, and ovr_irq = ovr_flag AND ovr_ie. Both flags remain readable while their enables are 0.
- R10: ovr_flag stays at 1 until an ovr_clr pulse arrives. If an overrun and ovr_clr fall in the same cycle, the flag stays set.
- R11: The queue holds at most 5 frames. A sixth admitted frame is lost unless a release occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fd_strobe | input | 1 | Frame completed this cycle |
| fd_ok | input | 1 | Frame received without error |
| fd_acc | input | 1 | Identifier passed the acceptance filter |
| fd_self | input | 1 | Frame was sent by this node |
| loopback | input | 1 | Treat own frames as received frames |
| fd_id | input | 32 | Identifier field |
| fd_dlc | input | 4 | Data length code |
| fd_data | input | 64 | Eight data bytes |
| fd_hit | input | 3 | Index of the matching filter |
| cpu_release | input | 1 | CPU acknowledges the head frame |
| ovr_clr | input | 1 | Write-one-to-clear pulse for ovr_flag |
| rx_ie | input | 1 | Receive interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| hd_id | output | 32 | Head frame identifier |
| hd_dlc | output | 4 | Head frame data length code |
| hd_data | output | 64 | Head frame data |
| hd_hit | output | 3 | Head frame filter index |
| rx_full | output | 1 | Queue holds a frame |
| rx_irq | output | 1 | Receive interrupt |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The assertions take these input properties for granted:
- cpu_release and ovr_clr are one-cycle pulses sampled at clock edges.
- fd_strobe marks a frame completion in a single cycle, and its qualifier inputs are valid in that same cycle.

The stimulus drives every input on the falling edge, so each pulse covers exactly one rising edge. The random phases switch to a low release rate so that the queue fills and overrun occurs. Directed cases cover the remaining boundaries:
- release on an empty queue;
- a release and a write in the same cycle on a full queue;
- an overrun and a clear in the same cycle.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  parameter int ID_W   = 32;
  parameter int DLC_W  = 4;
  parameter int NBYTES = 8;
  parameter int HIT_W  = 3;
  localparam int DATA_W = NBYTES * 8;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
    logic [HIT_W-1:0]  hit;
  } rx_frame_t;

  // Admission rule: clean, accepted, and not our own unless looped back
  function automatic logic rx_admit(input logic ok, input logic acc,
                                    input logic self_tx, input logic lb);
    return ok && acc && (!self_tx || lb);
  endfunction
endpackage

// File: rtl/can_rx_bgbuf.sv
module can_rx_bgbuf
  import can_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      done,
  input  logic      ok,
  input  logic      acc,
  input  logic      self_tx,
  input  logic      lb,
  input  rx_frame_t frame_in,
  output rx_frame_t bg_frame,
  output logic      commit
);
  logic admit_now;
  assign admit_now = done && rx_admit(ok, acc, self_tx, lb);

  // Scratch buffer: every completed frame lands here, good or bad
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_frame <= '0;
      commit   <= 1'b0;
    end else begin
      if (done) bg_frame <= frame_in;
      commit <= admit_now;
    end
  end

  p_self_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && self_tx && !lb) |=> !commit);
  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!ok || !acc)) |=> !commit);
endmodule

// File: rtl/can_rx_ring.sv
module can_rx_ring
  import can_rx_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_frame_t wdata,
  input  logic      pop_req,
  output rx_frame_t head,
  output logic      not_empty,
  output logic      ovr_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  rx_frame_t        slots [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             pop, push_ok;

  assign pop       = pop_req && (count != '0);
  assign push_ok   = push && ((count != CNT_MAX) || pop);
  assign ovr_evt   = push && !push_ok;
  assign not_empty = (count != '0);
  assign head      = slots[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop)     rd_ptr <= ptr_next(rd_ptr);
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= wdata;
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);
  p_empty_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop_req && !push) |=> (count == '0));
  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_req && count < CNT_MAX) |=> (count == $past(count) + 1'b1));
  p_swap_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_req && count == CNT_MAX) |-> !ovr_evt);
endmodule

// File: rtl/can_rx_ovr.sv
module can_rx_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
  import can_rx_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fd_strobe,
  input  logic              fd_ok,
  input  logic              fd_acc,
  input  logic              fd_self,
  input  logic              loopback,
  input  logic [ID_W-1:0]   fd_id,
  input  logic [DLC_W-1:0]  fd_dlc,
  input  logic [DATA_W-1:0] fd_data,
  input  logic [HIT_W-1:0]  fd_hit,
  input  logic              cpu_release,
  input  logic              ovr_clr,
  input  logic              rx_ie,
  input  logic              ovr_ie,
  output logic [ID_W-1:0]   hd_id,
  output logic [DLC_W-1:0]  hd_dlc,
  output logic [DATA_W-1:0] hd_data,
  output logic [HIT_W-1:0]  hd_hit,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              ovr_flag,
  output logic              ovr_irq
);
  rx_frame_t frame_in, bg_frame, head;
  logic      commit, ovr_evt;

  assign frame_in = '{id: fd_id, dlc: fd_dlc, data: fd_data, hit: fd_hit};

  can_rx_bgbuf u_bg (
    .clk(clk), .rst_n(rst_n), .done(fd_strobe), .ok(fd_ok), .acc(fd_acc),
    .self_tx(fd_self), .lb(loopback), .frame_in(frame_in),
    .bg_frame(bg_frame), .commit(commit)
  );

  can_rx_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(commit), .wdata(bg_frame),
    .pop_req(cpu_release), .head(head), .not_empty(rx_full), .ovr_evt(ovr_evt)
  );

  can_rx_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .set_evt(ovr_evt), .clr(ovr_clr), .flag(ovr_flag)
  );

  assign hd_id   = head.id;
  assign hd_dlc  = head.dlc;
  assign hd_data = head.data;
  assign hd_hit  = head.hit;
  assign rx_irq  = rx_full && rx_ie;
  assign ovr_irq = ovr_flag && ovr_ie;

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_irq) |-> ovr_ie);
endmodule

// File: tb/can_rx_fifo_test.sv
module can_rx_fifo_test;
  import can_rx_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fd_strobe = 0, fd_ok = 0, fd_acc = 0, fd_self = 0, loopback = 0;
  logic [ID_W-1:0] fd_id = '0;
  logic [DLC_W-1:0] fd_dlc = '0;
  logic [DATA_W-1:0] fd_data = '0;
  logic [HIT_W-1:0] fd_hit = '0;
  logic cpu_release = 0, ovr_clr = 0, rx_ie = 0, ovr_ie = 0;
  logic [ID_W-1:0] hd_id;
  logic [DLC_W-1:0] hd_dlc;
  logic [DATA_W-1:0] hd_data;
  logic [HIT_W-1:0] hd_hit;
  logic rx_full, rx_irq, ovr_flag, ovr_irq;

  always #4 clk = ~clk;

  can_rx_fifo uut (.*);

  int n_chk = 0, n_fail = 0;
  rx_frame_t mq[$];
  logic m_pend = 1'b0;
  rx_frame_t m_pend_fr;
  logic m_ovr = 1'b0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench restatement of the admission rule (R2, R3, R4)
  function automatic logic want(input logic ok, input logic acc, input logic s, input logic lb);
    if (!ok || !acc) return 1'b0;
    if (s && !lb) return 1'b0;
    return 1'b1;
  endfunction

  // One cycle: inputs applied at negedge, model advanced, outputs checked next negedge
  task automatic cyc(input logic d, input logic ok, input logic acc, input logic s,
                     input logic lb, input logic rel, input logic clr, input rx_frame_t f);
    logic set;
    fd_strobe = d; fd_ok = ok; fd_acc = acc; fd_self = s; loopback = lb;
    fd_id = f.id; fd_dlc = f.dlc; fd_data = f.data; fd_hit = f.hit;
    cpu_release = rel; ovr_clr = clr;
    set = 1'b0;
    if (rel && mq.size() != 0) void'(mq.pop_front());
    if (m_pend) begin
      if (mq.size() < 5) mq.push_back(m_pend_fr);
      else set = 1'b1;
    end
    if (set) m_ovr = 1'b1;
    else if (clr) m_ovr = 1'b0;
    m_pend = d && want(ok, acc, s, lb);
    m_pend_fr = f;
    @(posedge clk);
    @(negedge clk);
    chk("R2 rx_full", 64'(rx_full), 64'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk("R5 head id", 64'(hd_id), 64'(mq[0].id));
      chk("R5 head data", hd_data, mq[0].data);
      chk("R5 head dlc/hit", 64'({hd_dlc, hd_hit}), 64'({mq[0].dlc, mq[0].hit}));
    end
    chk("R6 R10 ovr_flag", 64'(ovr_flag), 64'(m_ovr));
    chk("R9 rx_irq", 64'(rx_irq), 64'(rx_ie && mq.size() != 0));
    chk("R9 ovr_irq", 64'(ovr_irq), 64'(ovr_ie && m_ovr));
  endtask

  function automatic rx_frame_t mkf(input int k);
    rx_frame_t f;
    f.id = ID_W'(32'h1000_0000 + k * 7);
    f.dlc = DLC_W'(k);
    f.data = {32'(k * 13), 32'hA5A5_0000 + 32'(k)};
    f.hit = HIT_W'(k);
    return f;
  endfunction

  task automatic good(input int k, input logic rel);
    cyc(1, 1, 1, 0, 0, rel, 0, mkf(k));
  endtask

  task automatic idle(input logic rel, input logic clr);
    cyc(0, 0, 0, 0, 0, rel, clr, mkf(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4419));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rx_full", 64'(rx_full), 0);
    chk("R1 ovr_flag", 64'(ovr_flag), 0);
    chk("R1 irqs", 64'({rx_irq, ovr_irq}), 0);
    rx_ie = 1; ovr_ie = 1;

    // R8: release on empty queue
    idle(1, 0);
    chk("R8 release on empty", 64'(rx_full), 0);

    // R3: bad or unaccepted frames dropped
    cyc(1, 0, 1, 0, 0, 0, 0, mkf(1));
    cyc(1, 1, 0, 0, 0, 0, 0, mkf(2));
    idle(0, 0);
    chk("R3 rejected not stored", 64'(rx_full), 0);

    // R4: own frame without / with loopback
    cyc(1, 1, 1, 1, 0, 0, 0, mkf(3));
    idle(0, 0);
    chk("R4 own frame dropped", 64'(rx_full), 0);
    cyc(1, 1, 1, 1, 1, 0, 0, mkf(4));
    idle(0, 0);
    chk("R4 loopback frame stored", 64'(hd_id), 64'(mkf(4).id));
    idle(1, 0);

    // R11 / R6: fill five, sixth overruns
    for (int k = 10; k < 16; k++) good(k, 0);
    idle(0, 0);
    chk("R6 overrun set", 64'(ovr_flag), 1);
    chk("R11 head is first of five", 64'(hd_id), 64'(mkf(10).id));

    // R7: release and write together on full queue
    good(20, 0);
    idle(1, 0);
    chk("R7 head advanced", 64'(hd_id), 64'(mkf(11).id));

    // R10: overrun and clear in same cycle keeps flag; plain clear drops it
    idle(0, 1);
    chk("R10 cleared", 64'(ovr_flag), 0);
    good(21, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, mkf(0));
    chk("R10 set wins over clear", 64'(ovr_flag), 1);
    ovr_ie = 0;
    idle(0, 0);
    chk("R9 ovr_irq masked", 64'(ovr_irq), 0);
    idle(0, 1);

    // Random phases: low release rate then balanced
    for (int i = 0; i < 6000; i++) begin
      int rr;
      rr = (i < 3000) ? 12 : 35;
      if (($urandom % 50) == 0) rx_ie = $urandom % 2;
      if (($urandom % 50) == 0) ovr_ie = $urandom % 2;
      cyc($urandom % 2, ($urandom % 10) < 8, ($urandom % 10) < 8, ($urandom % 5) == 0,
          ($urandom % 10) < 3, ($urandom % 100) < rr, ($urandom % 10) == 0,
          mkf(int'($urandom % 100000)));
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule